// File: doc/BRIEF.md
# Bus-Cycle Wait-State Timing Controller

This block sets the length of every bus cycle issued by a small 8-bit audio coprocessor. When the sequencer starts a cycle it presents the address, a flag saying that the cycle carries no address (an idle cycle), two 2-bit wait-state selects and the boot-ROM-enable bit. The block sorts the cycle into one of two classes: on-chip (internal) or off-chip (external). It looks up a clock count in the table for that class and keeps `busy_o` high for that many clocks. It raises `done_o` in the last of those clocks.

The same `done_o` clock carries a timer-update strobe. It also carries the amount by which the peripheral timers should advance for this cycle. That amount comes from a third table. The select used to index it is the one that belongs to the cycle's class.

A cycle must be classed correctly even when the address does not matter. For example, the fourth clock of a 16-bit add, subtract or load from the direct page is an idle cycle, not a read. It must be issued with the idle flag so that it takes the internal length.

Top module: `buscyc_wait_ctrl`

## Requirements
- R1: A cycle started with `idle_i` = 1 is internal (`cls_int_o` = 1), whatever the address.
- R2: A non-idle access whose address bits [15:4] equal 0x00F (addresses 0x00F0 to 0x00FF) is internal. 0x00EF and 0x0100 are external.
- R3: A non-idle access at 0xFFC0 or above is internal only when `boot_en_i` = 1, and external otherwise. 0xFFBF is external.
- R4: An internal cycle lasts 2, 4, 10 or 248 clocks for `int_sel_i` = 0, 1, 2 or 3.
- R5: An external cycle lasts 2, 4, 10 or 20 clocks for `ext_sel_i` = 0, 1, 2 or 3.
- R6: The timer advance is 2, 4, 8 or 16 for select values 0 to 3. The select used is `int_sel_i` for internal cycles and `ext_sel_i` for external ones.
- R7: After a start is accepted, `busy_o` is high for exactly the cycle length in clocks, starting with the clock after the start edge. `done_o` is high for exactly one clock, the last busy clock.
- R8: `tick_o` pulses together with `done_o`. `tick_amt_o` and `cls_int_o` show that cycle's timer advance and class.
- R9: A `start_i` pulse, or a change to any cycle input, while `busy_o` is high has no effect on the running cycle's length, class or timer advance.
- R10: After reset `busy_o`, `done_o` and `tick_o` are 0, `cls_int_o` is 1 and `tick_amt_o` is 2. These are the values for selects of 0 and boot ROM enabled.
- R11: A start presented on the clock right after `done_o` is accepted: `busy_o` is high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock strobe that begins a bus cycle |
| addr_i | input | 16 | Address of the cycle |
| idle_i | input | 1 | Cycle carries no address |
| int_sel_i | input | 2 | Internal wait-state select |
| ext_sel_i | input | 2 | External wait-state select |
| boot_en_i | input | 1 | Boot ROM mapped at the top of memory |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Last clock of the cycle |
| tick_o | output | 1 | Timer-update strobe |
| tick_amt_o | output | 5 | Timer advance for the finished cycle |
| cls_int_o | output | 1 | Class of the current or last cycle (1 = internal) |

## Verification
The hardest case to reach from the ports is a start strobe with new inputs that lands in the middle of a running cycle. It has to arrive on a clock where the counter is neither just loaded nor expiring, and its effect only shows in the length measured at the next `done_o`. The driver re-asserts `start_i` on the first busy clock with inputs that pick a different class and a different table entry. The monitor then measures the full busy span and the timer advance reported at `done_o`. Back-to-back cycles are started on the clock right after `done_o`. This exercises the handover edge where the counter expires and reloads.

// File: rtl/buscyc_wait_pkg.sv
package buscyc_wait_pkg;
   localparam int unsigned ADDR_W_DEF = 16;
   localparam int unsigned SEL_W_DEF  = 2;
   localparam int unsigned LEN_W_DEF  = 8;
   localparam int unsigned TICK_W_DEF = 5;

   typedef enum logic {
      CLS_EXT = 1'b0,
      CLS_INT = 1'b1
   } cyc_class_e;
endpackage

// File: rtl/buscyc_classify.sv
module buscyc_classify #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IO_LSB    = 4,
   parameter int unsigned IO_PAGE   = 12'h00F,
   parameter int unsigned BOOT_BASE = 16'hFFC0,
   parameter bit          HAS_BOOT  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              idle_i,
   input  logic              boot_en_i,
   output buscyc_wait_pkg::cyc_class_e cls_o
);
   localparam int unsigned PAGE_W = ADDR_W - IO_LSB;

   if (IO_LSB >= ADDR_W) begin : g_bad_lsb
      $error("IO_LSB must be below ADDR_W");
   end
   if (BOOT_BASE >= (1 << ADDR_W)) begin : g_bad_boot
      $error("BOOT_BASE outside address space");
   end

   logic in_io;
   logic in_boot;

   assign in_io = (addr_i[ADDR_W-1:IO_LSB] == PAGE_W'(IO_PAGE));

   if (HAS_BOOT) begin : g_boot
      assign in_boot = boot_en_i && (addr_i >= ADDR_W'(BOOT_BASE));
   end else begin : g_no_boot
      logic unused_boot;
      assign unused_boot = boot_en_i;
      assign in_boot     = 1'b0;
   end

   assign cls_o = (idle_i || in_io || in_boot) ? buscyc_wait_pkg::CLS_INT
                                               : buscyc_wait_pkg::CLS_EXT;
endmodule

// File: rtl/buscyc_len_lut.sv
module buscyc_len_lut #(
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned TICK_W = 5,
   parameter int unsigned INT_LEN  [2**SEL_W] = '{2, 4, 10, 248},
   parameter int unsigned EXT_LEN  [2**SEL_W] = '{2, 4, 10, 20},
   parameter int unsigned TICK_TAB [2**SEL_W] = '{2, 4, 8, 16}
) (
   input  buscyc_wait_pkg::cyc_class_e cls_i,
   input  logic [SEL_W-1:0]  int_sel_i,
   input  logic [SEL_W-1:0]  ext_sel_i,
   output logic [LEN_W-1:0]  len_o,
   output logic [TICK_W-1:0] tick_o
);
   localparam int unsigned N_SEL = 2**SEL_W;

   for (genvar g = 0; g < N_SEL; g++) begin : g_chk
      if (INT_LEN[g] < 1 || INT_LEN[g] >= (1 << LEN_W)) begin : g_bad_int
         $error("internal length entry out of range");
      end
      if (EXT_LEN[g] < 1 || EXT_LEN[g] >= (1 << LEN_W)) begin : g_bad_ext
         $error("external length entry out of range");
      end
      if (TICK_TAB[g] >= (1 << TICK_W)) begin : g_bad_tick
         $error("timer advance entry out of range");
      end
   end

   logic [SEL_W-1:0] sel;
   assign sel = (cls_i == buscyc_wait_pkg::CLS_INT) ? int_sel_i : ext_sel_i;

   always_comb begin
      len_o  = '0;
      tick_o = '0;
      for (int i = 0; i < N_SEL; i++) begin
         if (sel == SEL_W'(i)) begin
            len_o  = (cls_i == buscyc_wait_pkg::CLS_INT) ? LEN_W'(INT_LEN[i])
                                                         : LEN_W'(EXT_LEN[i]);
            tick_o = TICK_W'(TICK_TAB[i]);
         end
      end
   end
endmodule

// File: rtl/buscyc_countdown.sv
module buscyc_countdown #(
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             busy_o,
   output logic             done_o
);
   logic [LEN_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= len_i - LEN_W'(1);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - LEN_W'(1);
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/buscyc_wait_ctrl.sv
module buscyc_wait_ctrl #(
   parameter int unsigned ADDR_W    = buscyc_wait_pkg::ADDR_W_DEF,
   parameter int unsigned SEL_W     = buscyc_wait_pkg::SEL_W_DEF,
   parameter int unsigned LEN_W     = buscyc_wait_pkg::LEN_W_DEF,
   parameter int unsigned TICK_W    = buscyc_wait_pkg::TICK_W_DEF,
   parameter int unsigned IO_LSB    = 4,
   parameter int unsigned IO_PAGE   = 12'h00F,
   parameter int unsigned BOOT_BASE = 16'hFFC0,
   parameter bit          HAS_BOOT  = 1'b1,
   parameter int unsigned INT_LEN  [2**SEL_W] = '{2, 4, 10, 248},
   parameter int unsigned EXT_LEN  [2**SEL_W] = '{2, 4, 10, 20},
   parameter int unsigned TICK_TAB [2**SEL_W] = '{2, 4, 8, 16}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              idle_i,
   input  logic [SEL_W-1:0]  int_sel_i,
   input  logic [SEL_W-1:0]  ext_sel_i,
   input  logic              boot_en_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              tick_o,
   output logic [TICK_W-1:0] tick_amt_o,
   output logic              cls_int_o
);
   import buscyc_wait_pkg::*;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must be 1 to 4");
   end

   cyc_class_e        cls_live;
   cyc_class_e        cls_q;
   logic [LEN_W-1:0]  len_live;
   logic [TICK_W-1:0] tick_live;
   logic [TICK_W-1:0] tick_q;
   logic              accept;

   buscyc_classify #(
      .ADDR_W(ADDR_W), .IO_LSB(IO_LSB), .IO_PAGE(IO_PAGE),
      .BOOT_BASE(BOOT_BASE), .HAS_BOOT(HAS_BOOT)
   ) u_classify (
      .addr_i(addr_i), .idle_i(idle_i), .boot_en_i(boot_en_i), .cls_o(cls_live)
   );

   buscyc_len_lut #(
      .SEL_W(SEL_W), .LEN_W(LEN_W), .TICK_W(TICK_W),
      .INT_LEN(INT_LEN), .EXT_LEN(EXT_LEN), .TICK_TAB(TICK_TAB)
   ) u_lut (
      .cls_i(cls_live), .int_sel_i(int_sel_i), .ext_sel_i(ext_sel_i),
      .len_o(len_live), .tick_o(tick_live)
   );

   assign accept = start_i && !busy_o;

   buscyc_countdown #(.LEN_W(LEN_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .len_i(len_live),
      .busy_o(busy_o), .done_o(done_o)
   );

   // Reset state matches selects of 0 with boot ROM enabled (idle class).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q  <= CLS_INT;
         tick_q <= TICK_W'(TICK_TAB[0]);
      end else if (accept) begin
         cls_q  <= cls_live;
         tick_q <= tick_live;
      end
   end

   assign tick_o     = done_o;
   assign tick_amt_o = tick_q;
   assign cls_int_o  = (cls_q == CLS_INT);
endmodule

// File: rtl/buscyc_wait_chk.sv
module buscyc_wait_chk #(
   parameter int unsigned TICK_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              tick_o,
   input logic [TICK_W-1:0] tick_amt_o,
   input logic              cls_int_o
);
   assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_busy_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> !busy_o);

   assert_tick_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> done_o);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o |=> busy_o && $stable(tick_amt_o) && $stable(cls_int_o));

   assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);
endmodule

bind buscyc_wait_ctrl buscyc_wait_chk #(.TICK_W(TICK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .tick_o(tick_o), .tick_amt_o(tick_amt_o),
   .cls_int_o(cls_int_o)
);

// File: tb/buscyc_wait_ctrl_bench.sv
module buscyc_wait_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic        idle_i = 1'b0;
   logic [1:0]  int_sel_i = '0;
   logic [1:0]  ext_sel_i = '0;
   logic        boot_en_i = 1'b1;
   logic        busy_o, done_o, tick_o, cls_int_o;
   logic [4:0]  tick_amt_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      int    len;
      bit    cls;
      int    amt;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #5ns clk = ~clk;

   buscyc_wait_ctrl u_buscyc_wait_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .idle_i(idle_i), .int_sel_i(int_sel_i), .ext_sel_i(ext_sel_i),
      .boot_en_i(boot_en_i), .busy_o(busy_o), .done_o(done_o),
      .tick_o(tick_o), .tick_amt_o(tick_amt_o), .cls_int_o(cls_int_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit ref_int(input logic [15:0] a, input bit idl, input bit boot);
      if (idl) return 1'b1;
      if (a >= 16'h00F0 && a <= 16'h00FF) return 1'b1;
      if (boot && a >= 16'hFFC0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int ref_len(input bit internal, input int s);
      int ti[4] = '{2, 4, 10, 248};
      int te[4] = '{2, 4, 10, 20};
      return internal ? ti[s] : te[s];
   endfunction

   function automatic int ref_amt(input int s);
      int tt[4] = '{2, 4, 8, 16};
      return tt[s];
   endfunction

   // Driver: pushes the expected item, issues the start, optionally perturbs.
   task automatic drive(input string tag, input logic [15:0] a, input bit idl,
                        input int is, input int es, input bit boot, input bit perturb);
      exp_t e;
      e.cls = ref_int(a, idl, boot);
      e.len = ref_len(e.cls, e.cls ? is : es);
      e.amt = ref_amt(e.cls ? is : es);
      e.tag = tag;
      @(negedge clk);
      sb.push_back(e);
      addr_i = a; idle_i = idl; int_sel_i = 2'(is); ext_sel_i = 2'(es);
      boot_en_i = boot; start_i = 1'b1;
      @(negedge clk);
      check({tag, " R11 start accepted"}, int'(busy_o), 1);
      if (perturb) begin
         // R9: restart with inputs that pick another class and entry
         addr_i = e.cls ? 16'h4000 : 16'h00F8; idle_i = 1'b0;
         int_sel_i = 2'(3 - is); ext_sel_i = 2'(3 - es); boot_en_i = ~boot;
         start_i = 1'b1;
         @(negedge clk);
      end
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
   endtask

   // Monitor: measures the busy span and compares at done.
   int  busy_cnt = 0;
   bit  prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy_o) busy_cnt++;
         if (done_o && prev_done) check("R7 done single pulse", 1, 0);
         if (done_o) begin
            if (sb.size() == 0) begin
               check("R7 done with nothing expected", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " R7 busy length"}, busy_cnt, e.len);
               check({e.tag, " R8 tick strobe"}, int'(tick_o), 1);
               check({e.tag, " R6 timer advance"}, int'(tick_amt_o), e.amt);
               check({e.tag, " R8 class"}, int'(cls_int_o), int'(e.cls));
            end
            busy_cnt = 0;
         end
         prev_done = done_o;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 busy after reset", int'(busy_o), 0);
      check("R10 done after reset", int'(done_o), 0);
      check("R10 tick after reset", int'(tick_o), 0);
      check("R10 class after reset", int'(cls_int_o), 1);
      check("R10 advance after reset", int'(tick_amt_o), 2);
      rst_n = 1'b1;
      drive("R1 idle sel3 R4",     16'h1234, 1'b1, 3, 0, 1'b0, 1'b0);
      drive("R2 io low R4",        16'h00F0, 1'b0, 1, 2, 1'b1, 1'b1);
      drive("R2 io high R4",       16'h00FF, 1'b0, 2, 0, 1'b0, 1'b0);
      drive("R2 below io R5",      16'h00EF, 1'b0, 0, 3, 1'b1, 1'b1);
      drive("R2 above io R5",      16'h0100, 1'b0, 2, 1, 1'b1, 1'b0);
      drive("R3 boot on R4",       16'hFFC0, 1'b0, 0, 3, 1'b1, 1'b1);
      drive("R3 boot off R5",      16'hFFFF, 1'b0, 3, 2, 1'b0, 1'b0);
      drive("R3 below boot R6",    16'hFFBF, 1'b0, 3, 0, 1'b1, 1'b1);
      drive("R6 internal sel R9",  16'h00F5, 1'b0, 0, 3, 1'b0, 1'b1);
      drive("R5 ext sel0 R11",     16'h2000, 1'b0, 1, 0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      check("R7 busy low after last", int'(busy_o), 0);
      check("R7 all cycles ended", sb.size(), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule